// File: doc/BRIEF.md
# Dual-Word SHA-2 Message Schedule Expander

This block generates the message schedule for a SHA-2 compression core that performs two rounds in each clock. A padder delivers the sixteen words of a padded message block one per cycle. Once the last of them arrives, the expander starts a compute phase. In each cycle of that phase it presents an even/odd pair of schedule words, W(2k) and W(2k+1), together with the pair index k. The first eight pairs are the message words unchanged. Every later word is produced by the SHA-2 recurrence from a sixteen-word sliding window that moves forward two entries per cycle.

A single mode input selects between 32-bit words with a 64-word schedule and 64-bit words with an 80-word schedule. The small-sigma rotation and shift amounts change with the mode. The mode is captured when the first word of a block is accepted and stays fixed until that block has been fully expanded. All words travel on a 64-bit path. In 32-bit mode only the low half of that path is meaningful.

Top module: `sha2_sched_pair`

## Requirements
- R1: After reset, `pair_valid` and `pair_last` are low and the block is idle, waiting for the first load word.
- R2: While idle, each cycle with `load_valid` high accepts one `load_word`. After the sixteenth accepted word, `pair_valid` is high from the next cycle onward, with `pair_idx` equal to 0.
- R3: Pairs 0 to 7 present the loaded words in arrival order. `w_even` is W(2k) and `w_odd` is W(2k+1), where W(0) is the first word loaded.
- R4: For t ≥ 16, W(t) = s1(W(t-2)) + W(t-7) + s0(W(t-15)) + W(t-16), taken modulo 2 to the power of the word width.
- R5: In 32-bit mode (`mode_wide` = 0), s0(x) = ROTR7 ^ ROTR18 ^ SHR3 and s1(x) = ROTR17 ^ ROTR19 ^ SHR10, all on 32-bit words.
- R6: In 64-bit mode (`mode_wide` = 1), s0(x) = ROTR1 ^ ROTR8 ^ SHR7 and s1(x) = ROTR19 ^ ROTR61 ^ SHR6, all on 64-bit words.
- R7: A block produces 32 pairs in 32-bit mode and 40 pairs in 64-bit mode. `pair_last` is high exactly on the final pair. `pair_valid` is low in the cycle after it.
- R8: The mode is sampled together with the first word of a block. Changes on `mode_wide` later in the load or compute phases have no effect on that block.
- R9: In 32-bit mode, bits 63:32 of `load_word` are ignored, and bits 63:32 of `w_even` and `w_odd` are zero.
- R10: `load_valid` and `load_word` are ignored during the compute phase.
- R11: Pairs are issued on consecutive cycles without gaps, and `pair_idx` rises by one on each pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wide | input | 1 | 1 selects 64-bit words and 80 rounds, 0 selects 32-bit words and 64 rounds |
| load_valid | input | 1 | A message word is present on `load_word` |
| load_word | input | 64 | Message word, first word of the block first |
| pair_valid | output | 1 | A schedule pair is present |
| pair_last | output | 1 | The present pair is the last pair of the block |
| pair_idx | output | 6 | Pair index k |
| w_even | output | 64 | Schedule word W(2k) |
| w_odd | output | 64 | Schedule word W(2k+1) |

## Verification
Blocks of all-zero, all-one, walking-one, counting and pseudo-random words are expanded in both modes. The constant blocks expose carry and mask errors. Walking ones show which rotation or shift amount is wrong, and random words exercise the recurrence taps as a whole. Further 32-bit blocks carry junk in the upper half of each load word. Other blocks flip the mode after the first word, and some hold `load_valid` high with junk data during the compute phase. Each of these shows up as wrong schedule words if the block fails to ignore that stimulus.

// File: rtl/sha2_sched_pair.sv
module sha2_sched_pair #(
  parameter int WMAX    = 64,
  parameter int WNARROW = 32,
  parameter int WIN     = 16,
  parameter int SCHED_N = 64,
  parameter int SCHED_W = 80
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              mode_wide,
  input  logic                              load_valid,
  input  logic [WMAX-1:0]                   load_word,
  output logic                              pair_valid,
  output logic                              pair_last,
  output logic [$clog2(SCHED_W/2)-1:0]      pair_idx,
  output logic [WMAX-1:0]                   w_even,
  output logic [WMAX-1:0]                   w_odd
);
  localparam int IDXW = $clog2(SCHED_W/2);
  localparam int LDW  = $clog2(WIN);
  localparam logic [IDXW-1:0] LAST_N = IDXW'(SCHED_N/2 - 1);
  localparam logic [IDXW-1:0] LAST_W = IDXW'(SCHED_W/2 - 1);

  logic            computing;
  logic            mode_q;
  logic [LDW-1:0]  ld_cnt;
  logic [WMAX-1:0] win [WIN];
  logic [WMAX-1:0] new0, new1;
  logic            mode_ld;

  function automatic logic [WMAX-1:0] fit(input logic [WMAX-1:0] x, input logic wide);
    return wide ? x : WMAX'(x[WNARROW-1:0]);
  endfunction

  function automatic logic [WMAX-1:0] rotr(input logic [WMAX-1:0] x, input int n, input logic wide);
    logic [WNARROW-1:0] lo;
    lo = x[WNARROW-1:0];
    if (wide) return (x >> n) | (x << (WMAX - n));
    return WMAX'((lo >> n) | (lo << (WNARROW - n)));
  endfunction

  function automatic logic [WMAX-1:0] sig0(input logic [WMAX-1:0] x, input logic wide);
    if (wide) return rotr(x, 1, 1'b1) ^ rotr(x, 8, 1'b1) ^ (x >> 7);
    return rotr(x, 7, 1'b0) ^ rotr(x, 18, 1'b0) ^ (fit(x, 1'b0) >> 3);
  endfunction

  function automatic logic [WMAX-1:0] sig1(input logic [WMAX-1:0] x, input logic wide);
    if (wide) return rotr(x, 19, 1'b1) ^ rotr(x, 61, 1'b1) ^ (x >> 6);
    return rotr(x, 17, 1'b0) ^ rotr(x, 19, 1'b0) ^ (fit(x, 1'b0) >> 10);
  endfunction

  assign new0 = fit(sig1(win[WIN-2], mode_q) + win[WIN-7] + sig0(win[1], mode_q) + win[0], mode_q);
  assign new1 = fit(sig1(win[WIN-1], mode_q) + win[WIN-6] + sig0(win[2], mode_q) + win[1], mode_q);

  assign mode_ld    = (ld_cnt == '0) ? mode_wide : mode_q;
  assign pair_valid = computing;
  assign pair_last  = computing && (pair_idx == (mode_q ? LAST_W : LAST_N));
  assign w_even     = win[0];
  assign w_odd      = win[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      computing <= 1'b0;
      mode_q    <= 1'b0;
      ld_cnt    <= '0;
      pair_idx  <= '0;
      for (int j = 0; j < WIN; j++) win[j] <= '0;
    end else if (computing) begin
      for (int j = 0; j < WIN-2; j++) win[j] <= win[j+2];
      win[WIN-2] <= new0;
      win[WIN-1] <= new1;
      if (pair_last) begin
        computing <= 1'b0;
        pair_idx  <= '0;
      end else begin
        pair_idx  <= pair_idx + 1'b1;
      end
    end else if (load_valid) begin
      for (int j = 0; j < WIN-1; j++) win[j] <= win[j+1];
      win[WIN-1] <= fit(load_word, mode_ld);
      mode_q     <= mode_ld;
      if (ld_cnt == LDW'(WIN-1)) begin
        ld_cnt    <= '0;
        computing <= 1'b1;
      end else begin
        ld_cnt    <= ld_cnt + 1'b1;
      end
    end
  end
endmodule

module sha2_sched_pair_chk #(
  parameter int WMAX    = 64,
  parameter int WNARROW = 32,
  parameter int SCHED_N = 64,
  parameter int SCHED_W = 80
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         pair_valid,
  input logic                         pair_last,
  input logic [$clog2(SCHED_W/2)-1:0] pair_idx,
  input logic [WMAX-1:0]              w_even,
  input logic [WMAX-1:0]              w_odd,
  input logic                         mode_q
);
  localparam int IDXW = $clog2(SCHED_W/2);

  assert_pair_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && !pair_last |=> pair_valid && pair_idx == IDXW'($past(pair_idx) + 1'b1));

  assert_end_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_last |=> !pair_valid);

  assert_last_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_last |-> pair_idx == (mode_q ? IDXW'(SCHED_W/2 - 1) : IDXW'(SCHED_N/2 - 1)));

  assert_first_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pair_valid) |-> pair_idx == '0);

  assert_narrow_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && !mode_q |-> w_even[WMAX-1:WNARROW] == '0 && w_odd[WMAX-1:WNARROW] == '0);

  assert_mode_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pair_valid && $past(pair_valid) |-> $stable(mode_q));
endmodule

bind sha2_sched_pair sha2_sched_pair_chk #(
  .WMAX(WMAX), .WNARROW(WNARROW), .SCHED_N(SCHED_N), .SCHED_W(SCHED_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pair_valid(pair_valid), .pair_last(pair_last),
  .pair_idx(pair_idx), .w_even(w_even), .w_odd(w_odd), .mode_q(mode_q)
);

// File: tb/sha2_sched_pair_bench.sv
module sha2_sched_pair_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_wide = 1'b0;
  logic        load_valid = 1'b0;
  logic [63:0] load_word = '0;
  logic        pair_valid, pair_last;
  logic [5:0]  pair_idx;
  logic [63:0] w_even, w_odd;

  int n_cmp = 0;
  int n_bad = 0;
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;
  logic [63:0] exp_w [80];
  logic [63:0] blk [16];

  always #4 clk = ~clk;

  sha2_sched_pair u_sha2_sched_pair (
    .clk(clk), .rst_n(rst_n), .mode_wide(mode_wide), .load_valid(load_valid),
    .load_word(load_word), .pair_valid(pair_valid), .pair_last(pair_last),
    .pair_idx(pair_idx), .w_even(w_even), .w_odd(w_odd)
  );

  function automatic logic [63:0] msk(input logic [63:0] x, input bit wide);
    return wide ? x : {32'h0, x[31:0]};
  endfunction

  function automatic logic [63:0] brot(input logic [63:0] x, input int n, input bit wide);
    logic [127:0] d;
    logic [63:0]  s;
    if (wide) begin
      d = {x, x} >> n;
      return d[63:0];
    end
    s = {x[31:0], x[31:0]} >> n;
    return {32'h0, s[31:0]};
  endfunction

  function automatic logic [63:0] bs0(input logic [63:0] x, input bit wide);
    if (wide) return brot(x, 1, 1) ^ brot(x, 8, 1) ^ (x >> 7);
    return brot(x, 7, 0) ^ brot(x, 18, 0) ^ ({32'h0, x[31:0]} >> 3);
  endfunction

  function automatic logic [63:0] bs1(input logic [63:0] x, input bit wide);
    if (wide) return brot(x, 19, 1) ^ brot(x, 61, 1) ^ (x >> 6);
    return brot(x, 17, 0) ^ brot(x, 19, 0) ^ ({32'h0, x[31:0]} >> 10);
  endfunction

  function automatic logic [63:0] nxt_rng(input logic [63:0] x);
    logic [63:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 7);
    return y ^ (y << 17);
  endfunction

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R4 recurrence with R5/R6 sigmas, computed from the raw block
  task automatic build_expect(input bit wide);
    for (int t = 0; t < 80; t++) begin
      if (t < 16) exp_w[t] = msk(blk[t], wide);
      else exp_w[t] = msk(bs1(exp_w[t-2], wide) + exp_w[t-7] + bs0(exp_w[t-15], wide) + exp_w[t-16], wide);
    end
  endtask

  task automatic fill_block(input int pat);
    for (int i = 0; i < 16; i++) begin
      case (pat)
        0: blk[i] = '0;
        1: blk[i] = '1;
        2: blk[i] = 64'h1 << ((i * 5) % 64);
        3: blk[i] = 64'h0101_0101_0101_0101 * (i + 1);
        default: begin rng = nxt_rng(rng); blk[i] = rng; end
      endcase
    end
  endtask

  task automatic run_block(input bit wide, input string tag, input bit junk, input bit flip, input bit poke);
    int np;
    np = wide ? 40 : 32;
    build_expect(wide);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      mode_wide  = (flip && i > 0) ? !wide : wide;
      load_valid = 1'b1;
      load_word  = junk ? {~blk[i][31:0] ^ 32'hA5A5_5A5A, blk[i][31:0]} : blk[i];
    end
    @(negedge clk);
    load_valid = poke;
    load_word  = 64'hDEAD_BEEF_CAFE_F00D;
    if (poke || flip) mode_wide = !wide;
    check64({"R2 ", tag, " valid after 16th word"}, 64'(pair_valid), 64'd1);
    for (int k = 0; k < np; k++) begin
      if (k > 0) @(negedge clk);
      if (poke) load_word = load_word + 64'h1111;
      check64({"R11 ", tag, " pair index"}, 64'(pair_idx), 64'(k));
      check64({(k < 8) ? "R3 " : (wide ? "R4 R6 " : "R4 R5 "), tag, " even word"}, w_even, exp_w[2*k]);
      check64({(k < 8) ? "R3 " : (wide ? "R4 R6 " : "R4 R5 "), tag, " odd word"}, w_odd, exp_w[2*k+1]);
      check64({"R7 ", tag, " last flag"}, 64'(pair_last), 64'(k == np - 1));
      check64({"R11 ", tag, " valid held"}, 64'(pair_valid), 64'd1);
    end
    @(negedge clk);
    load_valid = 1'b0;
    check64({"R7 ", tag, " idle after last"}, 64'(pair_valid), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check64("R1 valid at reset", 64'(pair_valid), 64'd0);
    check64("R1 last at reset", 64'(pair_last), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check64("R1 idle after reset", 64'(pair_valid), 64'd0);
    for (int m = 0; m < 2; m++) begin
      for (int p = 0; p < 6; p++) begin
        fill_block(p);
        run_block(bit'(m), "plain", 1'b0, 1'b0, 1'b0);
      end
    end
    fill_block(5);
    run_block(1'b0, "R9 upper junk", 1'b1, 1'b0, 1'b0);
    fill_block(5);
    run_block(1'b0, "R8 mode flip", 1'b0, 1'b1, 1'b0);
    fill_block(5);
    run_block(1'b1, "R8 mode flip", 1'b0, 1'b1, 1'b0);
    fill_block(5);
    run_block(1'b0, "R10 load in compute", 1'b0, 1'b0, 1'b1);
    fill_block(5);
    run_block(1'b1, "R10 load in compute", 1'b0, 1'b0, 1'b1);
    fill_block(2);
    run_block(1'b0, "R9 R10 junk and poke", 1'b1, 1'b1, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule